// File: doc/BRIEF.md
# Triggered Circular Capture Controller

This block is the recording half of an on-chip signal probe. Once armed, it takes one sample of a probe vector on every clock and sends it to an external circular buffer as a write address, write data and write enable. At the same time it watches one selected bit of the vector for a trigger condition. Four conditions are available: a rising edge, a falling edge, a level held high for three samples, or a level held low for three samples.

The pre-trigger share of the window is set as a percentage. When the trigger fires, the block converts that percentage into a sample count. It keeps writing until the buffer holds the requested number of post-trigger samples, then stops. It then reports the first and last buffer addresses of the window, so a readout stage can walk the buffer in order. A small write port loads the configuration. A counter records how many samples were taken before the trigger.

Top module: `lac_capture_ctrl`

## Requirements
- R1: The trigger watches `probe_in[trig_sel]`, using only samples taken since arming. Kind code 0 fires on a sample of 1 that follows a sample of 0. Code 1 fires on a sample of 0 that follows a sample of 1. Code 2 fires on the third consecutive sample of 1. Code 3 fires on the third consecutive sample of 0.
- R2: `trig_found` goes high for exactly one cycle, in the cycle after the triggering sample is presented.
- R3: While capturing, `wr_en` is 1 and `wr_data` equals `probe_in`. `wr_addr` is 0 for the first sample after arming and advances by one per cycle, modulo DEPTH.
- R4: `cyc_to_trig` clears on arming. It then equals the number of samples taken before the triggering sample, saturating at 2^CW-1.
- R5: The pre-trigger count is P = min(floor(DEPTH*pos/100), DEPTH-1). A written position above 100 is held at 100.
- R6: After the triggering sample, exactly DEPTH-1-P more samples are written. Then `wr_en` stays 0.
- R7: `win_valid` rises only after the last write. At that point `win_start` = (T-P) mod DEPTH and `win_end` = (T+DEPTH-1-P) mod DEPTH, where T is the address of the triggering sample.
- R8: If fewer than P samples preceded the trigger, `win_start` is 0.
- R9: The register port uses `cfg_sel` values 0 for kind, 1 for position, 2 for enable (bit 0) and 3 for the probe index. Writes to kind, position and probe index are ignored while enabled. Writing enable 1 while it is 0 arms the block. Writing enable 0 returns it to idle, with `wr_en` and `win_valid` both 0.
- R10: Reset clears the configuration, the counter, the write address and all trigger state. Its active level is the parameter RST_ACTIVE_HIGH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Reset, active level set by RST_ACTIVE_HIGH |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 kind, 1 position, 2 enable, 3 probe index |
| cfg_wdata | input | 8 | Configuration write value |
| probe_in | input | NPROBE | Probed signals |
| wr_en | output | 1 | Buffer write enable |
| wr_addr | output | AW | Buffer write address |
| wr_data | output | NPROBE | Buffer write data |
| trig_found | output | 1 | One-cycle trigger strobe |
| cyc_to_trig | output | CW | Samples taken before the trigger |
| win_valid | output | 1 | Window addresses valid |
| win_start | output | AW | First address of the window |
| win_end | output | AW | Last address of the window |

## Verification
The bench sweeps every trigger kind against positions of 0, 25, 50, 99, 100 and an over-range 150, with triggers early, mid-buffer, after a wrap and past counter saturation. Each sweep point checks the window arithmetic. A design that mis-rounded the percentage, or failed to hold the count at DEPTH-1, would report shifted window addresses or write one sample too many. Early triggers with large positions exercise the start clamp, which an unclamped design would report as a wrapped address. Configuration writes made in mid-capture would, if accepted, change the trigger kind or window and break the expected trigger cycle.

// File: rtl/lac_pkg.sv
package lac_pkg;
   typedef enum logic [1:0] {
      TRG_RISE  = 2'd0,
      TRG_FALL  = 2'd1,
      TRG_HIGH3 = 2'd2,
      TRG_LOW3  = 2'd3
   } trig_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ARMED,
      ST_POST,
      ST_DONE
   } cap_state_e;

   typedef enum logic [1:0] {
      SEL_KIND = 2'd0,
      SEL_POS  = 2'd1,
      SEL_EN   = 2'd2,
      SEL_PROBE = 2'd3
   } cfg_sel_e;

   localparam int unsigned PCT_MAX   = 100;
   localparam int unsigned LEVEL_RUN = 3;
endpackage

// File: rtl/lac_cfg_regs.sv
module lac_cfg_regs
   import lac_pkg::*;
#(
   parameter int unsigned NPROBE = 8,
   parameter int unsigned SW     = 3
) (
   input  logic          clk,
   input  logic          rst_act,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_sel,
   input  logic [7:0]    cfg_wdata,
   output trig_kind_e    kind,
   output logic [6:0]    pct,
   output logic [SW-1:0] probe_sel,
   output logic          enable,
   output logic          arm,
   output logic          disarm
);
   logic wr_en_reg;
   logic locked_write;

   assign wr_en_reg    = cfg_we && (cfg_sel == SEL_EN);
   assign arm          = wr_en_reg && cfg_wdata[0] && !enable;
   assign disarm       = wr_en_reg && !cfg_wdata[0] && enable;
   assign locked_write = cfg_we && !enable;

   always_ff @(posedge clk) begin
      if (rst_act) begin
         kind      <= TRG_RISE;
         pct       <= '0;
         probe_sel <= '0;
         enable    <= 1'b0;
      end else begin
         if (arm) enable <= 1'b1;
         else if (disarm) enable <= 1'b0;
         if (locked_write) begin
            case (cfg_sel)
               SEL_KIND: kind <= trig_kind_e'(cfg_wdata[1:0]);
               SEL_POS:  pct  <= (cfg_wdata > 8'(PCT_MAX)) ? 7'(PCT_MAX) : cfg_wdata[6:0];
               SEL_PROBE: if (32'(cfg_wdata) < NPROBE) probe_sel <= cfg_wdata[SW-1:0];
               default: ;
            endcase
         end
      end
   end

   // R9: kind and position only change while disabled
   a_r9_cfg_locked: assert property (@(posedge clk) disable iff (rst_act)
      $past(enable) && enable |-> $stable(kind) && $stable(pct) && $stable(probe_sel));
   // R5: stored position never exceeds the percent ceiling
   a_r5_pct_bound: assert property (@(posedge clk) disable iff (rst_act)
      pct <= 7'(PCT_MAX));
endmodule

// File: rtl/lac_trig_detect.sv
module lac_trig_detect
   import lac_pkg::*;
(
   input  logic       clk,
   input  logic       rst_act,
   input  logic       clear,
   input  logic       sample,
   input  trig_kind_e kind,
   input  logic       level_in,
   output logic       hit
);
   localparam int unsigned RUN_MAX = LEVEL_RUN - 1;
   localparam int unsigned RW      = $clog2(RUN_MAX + 1);

   logic          prev;
   logic          have_prev;
   logic [RW-1:0] hi_run;
   logic [RW-1:0] lo_run;
   logic          cond;

   always_comb begin
      case (kind)
         TRG_RISE:  cond = have_prev && !prev && level_in;
         TRG_FALL:  cond = have_prev && prev && !level_in;
         TRG_HIGH3: cond = level_in && (hi_run == RW'(RUN_MAX));
         default:   cond = !level_in && (lo_run == RW'(RUN_MAX));
      endcase
   end

   assign hit = sample && cond;

   always_ff @(posedge clk) begin
      if (rst_act || clear) begin
         prev      <= 1'b0;
         have_prev <= 1'b0;
         hi_run    <= '0;
         lo_run    <= '0;
      end else if (sample) begin
         prev      <= level_in;
         have_prev <= 1'b1;
         if (level_in) begin
            lo_run <= '0;
            if (hi_run != RW'(RUN_MAX)) hi_run <= hi_run + 1'b1;
         end else begin
            hi_run <= '0;
            if (lo_run != RW'(RUN_MAX)) lo_run <= lo_run + 1'b1;
         end
      end
   end

   // R1: a rising-edge hit always follows a low sample
   a_r1_rise_edge: assert property (@(posedge clk) disable iff (rst_act)
      hit && kind == TRG_RISE && sample && $past(sample) && !$past(clear) |-> !$past(level_in));
endmodule

// File: rtl/lac_window_calc.sv
module lac_window_calc #(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned AW    = 8,
   parameter int unsigned CW    = 9
) (
   input  logic [6:0]    pct,
   input  logic [AW-1:0] trig_addr,
   input  logic [CW-1:0] prior,
   output logic [AW-1:0] start_addr,
   output logic [AW-1:0] end_addr,
   output logic [AW-1:0] post_len
);
   localparam int unsigned PW = AW + 8;

   logic [PW-1:0] prod;
   logic [PW-1:0] pre_raw;
   logic [PW-1:0] pre;
   logic [PW-1:0] post_w;

   always_comb begin
      prod    = PW'(DEPTH) * PW'(pct);
      pre_raw = prod / PW'(100);
      pre     = (pre_raw > PW'(DEPTH - 1)) ? PW'(DEPTH - 1) : pre_raw;
      post_w  = PW'(DEPTH - 1) - pre;
      post_len = post_w[AW-1:0];
      start_addr = (PW'(prior) < pre) ? '0 : (trig_addr - pre[AW-1:0]);
      end_addr   = trig_addr + post_w[AW-1:0];
   end
endmodule

// File: rtl/lac_capture_ctrl.sv
module lac_capture_ctrl
   import lac_pkg::*;
#(
   parameter int unsigned DEPTH           = 256,
   parameter int unsigned NPROBE          = 8,
   parameter bit          RST_ACTIVE_HIGH = 1'b1,
   localparam int unsigned AW = $clog2(DEPTH),
   localparam int unsigned CW = $clog2(DEPTH + 1),
   localparam int unsigned SW = (NPROBE > 1) ? $clog2(NPROBE) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [7:0]        cfg_wdata,
   input  logic [NPROBE-1:0] probe_in,
   output logic              wr_en,
   output logic [AW-1:0]     wr_addr,
   output logic [NPROBE-1:0] wr_data,
   output logic              trig_found,
   output logic [CW-1:0]     cyc_to_trig,
   output logic              win_valid,
   output logic [AW-1:0]     win_start,
   output logic [AW-1:0]     win_end
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (NPROBE < 1 || NPROBE > 256) begin : g_bad_probe
      $error("NPROBE must lie in 1..256");
   end

   logic          rst_act;
   trig_kind_e    kind;
   logic [6:0]    pct;
   logic [SW-1:0] probe_sel;
   logic          enable;
   logic          arm;
   logic          disarm;
   logic          trig_level;
   logic          hit;
   logic [AW-1:0] calc_start;
   logic [AW-1:0] calc_end;
   logic [AW-1:0] post_len;
   logic [AW-1:0] post_left;
   cap_state_e    state;

   assign rst_act = RST_ACTIVE_HIGH ? rst : ~rst;

   lac_cfg_regs #(.NPROBE(NPROBE), .SW(SW)) u_cfg (
      .clk(clk), .rst_act(rst_act), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .kind(kind), .pct(pct), .probe_sel(probe_sel),
      .enable(enable), .arm(arm), .disarm(disarm)
   );

   if (NPROBE == 1) begin : g_single
      assign trig_level = probe_in[0];
   end else begin : g_mux
      assign trig_level = probe_in[probe_sel];
   end

   lac_trig_detect u_det (
      .clk(clk), .rst_act(rst_act), .clear(arm),
      .sample(state == ST_ARMED), .kind(kind), .level_in(trig_level), .hit(hit)
   );

   lac_window_calc #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_win (
      .pct(pct), .trig_addr(wr_addr), .prior(cyc_to_trig),
      .start_addr(calc_start), .end_addr(calc_end), .post_len(post_len)
   );

   assign wr_en     = (state == ST_ARMED) || (state == ST_POST);
   assign wr_data   = probe_in;
   assign win_valid = (state == ST_DONE);

   always_ff @(posedge clk) begin
      if (rst_act) begin
         state       <= ST_IDLE;
         wr_addr     <= '0;
         cyc_to_trig <= '0;
         trig_found  <= 1'b0;
         post_left   <= '0;
         win_start   <= '0;
         win_end     <= '0;
      end else begin
         trig_found <= 1'b0;
         if (disarm) begin
            state <= ST_IDLE;
         end else if (arm) begin
            state       <= ST_ARMED;
            wr_addr     <= '0;
            cyc_to_trig <= '0;
         end else begin
            case (state)
               ST_ARMED: begin
                  wr_addr <= wr_addr + 1'b1;
                  if (hit) begin
                     trig_found <= 1'b1;
                     win_start  <= calc_start;
                     win_end    <= calc_end;
                     post_left  <= post_len;
                     state      <= (post_len == '0) ? ST_DONE : ST_POST;
                  end else if (cyc_to_trig != '1) begin
                     cyc_to_trig <= cyc_to_trig + 1'b1;
                  end
               end
               ST_POST: begin
                  wr_addr   <= wr_addr + 1'b1;
                  post_left <= post_left - 1'b1;
                  if (post_left == AW'(1)) state <= ST_DONE;
               end
               default: ;
            endcase
         end
      end
   end

   // R2: the trigger strobe lasts one cycle
   a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst_act)
      trig_found |=> !trig_found);
   // R2: the strobe follows a cycle spent searching
   a_r2_from_search: assert property (@(posedge clk) disable iff (rst_act)
      trig_found |-> $past(state) == ST_ARMED);
   // R3: consecutive writes use consecutive addresses
   a_r3_addr_step: assert property (@(posedge clk) disable iff (rst_act)
      wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + 1'b1);
   // R4: counter never moves backward during a search
   a_r4_count_monotone: assert property (@(posedge clk) disable iff (rst_act)
      state == ST_ARMED && $past(state) == ST_ARMED |-> cyc_to_trig >= $past(cyc_to_trig));
   // R6: no writes once the window is reported
   a_r6_no_write_done: assert property (@(posedge clk) disable iff (rst_act)
      win_valid |-> !wr_en);
   // R7: reported window addresses hold steady
   a_r7_window_stable: assert property (@(posedge clk) disable iff (rst_act)
      win_valid && $past(win_valid) |-> $stable(win_start) && $stable(win_end));
endmodule

// File: tb/lac_capture_ctrl_test.sv
module lac_capture_ctrl_test;
   localparam int D  = 16;
   localparam int NP = 4;
   localparam int AW = 4;
   localparam int CW = 5;
   localparam int TSEL = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_sel = '0;
   logic [7:0]    cfg_wdata = '0;
   logic [NP-1:0] probe_in = '0;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [NP-1:0] wr_data;
   logic          trig_found;
   logic [CW-1:0] cyc_to_trig;
   logic          win_valid;
   logic [AW-1:0] win_start;
   logic [AW-1:0] win_end;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   lac_capture_ctrl #(.DEPTH(D), .NPROBE(NP)) uut (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .probe_in(probe_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .trig_found(trig_found), .cyc_to_trig(cyc_to_trig), .win_valid(win_valid),
      .win_start(win_start), .win_end(win_end)
   );

   always #4 clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wcfg(input int sel, input int val);
      cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = 8'(val);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   function automatic bit lvl(input int kind, input int k, input int i);
      case (kind)
         0: return i >= k;
         1: return i < k;
         2: return i >= k - 2;
         default: return i < k - 2;
      endcase
   endfunction

   task automatic run(input int kind, input int pos, input int k, input bit poke);
      int pe, last, es, ee;
      wcfg(2, 0);
      chk("R9 idle wr_en", int'(wr_en), 0);
      chk("R9 idle win_valid", int'(win_valid), 0);
      wcfg(0, kind);
      wcfg(1, pos);
      wcfg(3, TSEL);
      pe = (D * ((pos > 100) ? 100 : pos)) / 100;
      if (pe > D - 1) pe = D - 1;
      last = k + D - 1 - pe;
      es = (k < pe) ? 0 : ((k - pe) % D);
      ee = (k + D - 1 - pe) % D;
      wcfg(2, 1);
      for (int i = 0; i <= last + 1; i++) begin
         if (i <= last) begin
            chk("R3/R6 wr_en", int'(wr_en), 1);
            chk("R3 wr_addr", int'(wr_addr), i % D);
         end else begin
            chk("R6 stop", int'(wr_en), 0);
         end
         chk("R2 trig_found", int'(trig_found), (i == k + 1) ? 1 : 0);
         if (i <= last) chk("R7 not yet valid", int'(win_valid), 0);
         if (poke && i == 0) begin cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 8'(kind ^ 1); end
         if (poke && i == 1) begin cfg_sel = 2'd1; cfg_wdata = 8'((pos == 0) ? 50 : 0); end
         if (poke && i == 2) begin cfg_sel = 2'd3; cfg_wdata = 8'(0); end
         if (poke && i == 3) cfg_we = 1'b0;
         probe_in = NP'(i);
         probe_in[TSEL] = lvl(kind, k, i);
         #1;
         if (i <= last) chk("R3 wr_data", int'(wr_data), int'(probe_in));
         @(negedge clk);
      end
      chk("R7 win_valid", int'(win_valid), 1);
      chk(k < pe ? "R8 clamped start" : "R7 win_start", int'(win_start), es);
      chk("R7 win_end", int'(win_end), ee);
      chk("R4 cyc_to_trig", int'(cyc_to_trig), (k > 31) ? 31 : k);
      chk("R1 kind fired once", int'(trig_found), 0);
   endtask

   initial begin
      int poslist[6];
      int klist[4];
      poslist = '{0, 25, 50, 99, 100, 150};
      klist   = '{2, 5, 20, 35};
      repeat (3) @(negedge clk);
      chk("R10 reset wr_en", int'(wr_en), 0);
      chk("R10 reset trig_found", int'(trig_found), 0);
      chk("R10 reset cyc", int'(cyc_to_trig), 0);
      chk("R10 reset addr", int'(wr_addr), 0);
      rst = 1'b0;
      @(negedge clk);
      for (int kd = 0; kd < 4; kd++)
         for (int p = 0; p < 6; p++)
            for (int q = 0; q < 4; q++)
               run(kd, poslist[p], klist[q], (q == 2));
      // R10: reset in mid-capture
      wcfg(2, 0);
      wcfg(2, 1);
      repeat (4) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R10 mid reset wr_en", int'(wr_en), 0);
      chk("R10 mid reset cyc", int'(cyc_to_trig), 0);
      chk("R10 mid reset valid", int'(win_valid), 0);
      chk("R10 mid reset addr", int'(wr_addr), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule